// File: doc/BRIEF.md
# Flash Block Reclamation Scheduler

This block keeps the bookkeeping for a small array of flash blocks under a page-mapped translation layer and runs the reclamation cycles that turn partly stale blocks back into erased, writable ones. Each page is in one of three states: erased, holding live data, or holding a superseded copy. Host notifications move pages between these states. A page is written in place of a clean one. When an update lands elsewhere, the old copy is marked stale.

A reclamation cycle first picks the block with the most stale pages. It then copies every live page of that block into a fully erased destination block, one read and one program at a time. Last, it erases the picked block, which returns it to the free pool. The cycle runs in the background only while the host reports idle. When the free pool shrinks below a threshold, the block stalls host writes and reclaims in the foreground whatever the host is doing. The stall is released only after the pool has grown one block past the threshold.

Flash operations go out on a valid/ready command stream. Once the block raises `cmd_valid`, it holds the operation fields steady until `cmd_ready` is seen high at a clock edge. That handshake means the operation is complete, so the flash side applies back-pressure simply by holding `cmd_ready` low. A power-down request lets any operation in flight complete, then parks the engine for good.

Top module: `gc_sched`

## Requirements
- R1: A host write notification marks a page live, and the block holding it leaves the free pool. An erase returns every page of the block to the erased state and puts the block back in the free pool, where it can serve as a later destination.
- R2: The victim is the block with the largest number of stale pages; among blocks with equal counts the lowest block index wins.
- R3: A block with no stale pages is never a victim; when no block has stale pages no command is issued.
- R4: A cycle issues, for each live page of the victim in ascending page order, a read (cmd_op 0) of that page followed by a program (cmd_op 1) into the destination. Destination pages are filled in ascending order starting at page 0. The destination is the lowest-index free block. The cycle ends with one erase (cmd_op 2) of the victim, with cmd_page 0.
- R5: While host_stall is low, no new command is raised unless host_idle was high in the cycle before.
- R6: host_stall rises in the cycle after the free-block count drops below FREE_THRESH. While it is high, reclamation runs whatever the state of host_idle.
- R7: host_stall falls in the cycle after the free-block count exceeds FREE_THRESH; at exactly FREE_THRESH it keeps its value.
- R8: Host write notifications that arrive while host_stall is high are ignored.
- R9: After a power-down request, the operation in flight completes. No further command is raised, in particular no erase, and halted stays high until reset.
- R10: While cmd_valid is high and cmd_ready low, cmd_valid, cmd_op, cmd_blk and cmd_page keep their values.
- R11: After reset all blocks are free, and cmd_valid, host_stall and halted are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host wrote a page |
| wr_blk | input | clog2(NUM_BLKS) | Block of the written page |
| wr_page | input | clog2(PAGES_PER_BLK) | Page index of the written page |
| inv_en | input | 1 | Host superseded a page |
| inv_blk | input | clog2(NUM_BLKS) | Block of the stale page |
| inv_page | input | clog2(PAGES_PER_BLK) | Page index of the stale page |
| host_idle | input | 1 | Host has no traffic; permits background cycles |
| pd_req | input | 1 | Power-down request pulse |
| cmd_valid | output | 1 | Flash operation offered |
| cmd_ready | input | 1 | Flash operation accepted and complete |
| cmd_op | output | 2 | 0 read, 1 program, 2 erase |
| cmd_blk | output | clog2(NUM_BLKS) | Target block |
| cmd_page | output | clog2(PAGES_PER_BLK) | Target page (0 for erase) |
| host_stall | output | 1 | Host writes are held off |
| halted | output | 1 | Engine parked after power-down |

## Verification
The hardest state to reach from the ports is the hysteresis band. Here the free count sits exactly at the threshold, the stall is still high, and foreground cycles keep running with the host busy. A single host write cannot get there while background cycles are racing it. The bench therefore fills two blocks and supersedes every page while host_idle is low, so nothing is reclaimed. One write to a third block then crosses the threshold, which forces two back-to-back foreground erases, and the stall is sampled between them and after them. A second hard spot is a power-down that arrives while a read is held by back-pressure. The bench keeps cmd_ready low, pulses the request, then completes the read and watches for silence.

// File: rtl/gc_pkg.sv
package gc_pkg;
  typedef enum logic [1:0] {
    PG_ERASED  = 2'd0,
    PG_LIVE    = 2'd1,
    PG_STALE   = 2'd2
  } pg_state_t;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2
  } flash_op_t;

  typedef enum logic [3:0] {
    S_IDLE, S_SCAN, S_RD_ARM, S_RD, S_PG_ARM, S_PG, S_ER_ARM, S_ER, S_HALT
  } eng_state_t;
endpackage

// File: rtl/gc_block_table.sv
module gc_block_table
  import gc_pkg::*;
#(
  parameter int NUM_BLKS      = 8,
  parameter int PAGES_PER_BLK = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic host_wr_en,
  input  logic [$clog2(NUM_BLKS)-1:0] host_wr_blk,
  input  logic [$clog2(PAGES_PER_BLK)-1:0] host_wr_page,
  input  logic host_inv_en,
  input  logic [$clog2(NUM_BLKS)-1:0] host_inv_blk,
  input  logic [$clog2(PAGES_PER_BLK)-1:0] host_inv_page,
  input  logic eng_prog_en,
  input  logic [$clog2(NUM_BLKS)-1:0] eng_prog_blk,
  input  logic [$clog2(PAGES_PER_BLK)-1:0] eng_prog_page,
  input  logic eng_erase_en,
  input  logic [$clog2(NUM_BLKS)-1:0] eng_erase_blk,
  output logic [NUM_BLKS-1:0][$clog2(PAGES_PER_BLK+1)-1:0] stale_cnt,
  output logic [NUM_BLKS-1:0][PAGES_PER_BLK-1:0] live_map,
  output logic [NUM_BLKS-1:0] blk_free,
  output logic [$clog2(NUM_BLKS+1)-1:0] free_cnt
);
  localparam int CNT_W  = $clog2(PAGES_PER_BLK+1);
  localparam int FCNT_W = $clog2(NUM_BLKS+1);

  pg_state_t st_q [NUM_BLKS][PAGES_PER_BLK];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NUM_BLKS; b++)
        for (int p = 0; p < PAGES_PER_BLK; p++)
          st_q[b][p] <= PG_ERASED;
    end else begin
      for (int b = 0; b < NUM_BLKS; b++) begin
        for (int p = 0; p < PAGES_PER_BLK; p++) begin
          if (eng_erase_en && int'(eng_erase_blk) == b)
            st_q[b][p] <= PG_ERASED;
          else if (eng_prog_en && int'(eng_prog_blk) == b && int'(eng_prog_page) == p)
            st_q[b][p] <= PG_LIVE;
          else if (host_wr_en && int'(host_wr_blk) == b && int'(host_wr_page) == p)
            st_q[b][p] <= PG_LIVE;
          else if (host_inv_en && int'(host_inv_blk) == b && int'(host_inv_page) == p
                   && st_q[b][p] == PG_LIVE)
            st_q[b][p] <= PG_STALE;
        end
      end
    end
  end

  always_comb begin
    free_cnt = '0;
    for (int b = 0; b < NUM_BLKS; b++) begin
      stale_cnt[b] = '0;
      blk_free[b]  = 1'b1;
      for (int p = 0; p < PAGES_PER_BLK; p++) begin
        live_map[b][p] = (st_q[b][p] == PG_LIVE);
        if (st_q[b][p] == PG_STALE) stale_cnt[b] = stale_cnt[b] + CNT_W'(1);
        if (st_q[b][p] != PG_ERASED) blk_free[b] = 1'b0;
      end
      if (blk_free[b]) free_cnt = free_cnt + FCNT_W'(1);
    end
  end
endmodule

// File: rtl/gc_victim_sel.sv
module gc_victim_sel #(
  parameter int NUM_BLKS      = 8,
  parameter int PAGES_PER_BLK = 16
) (
  input  logic [NUM_BLKS-1:0][$clog2(PAGES_PER_BLK+1)-1:0] stale_cnt,
  input  logic [NUM_BLKS-1:0] blk_free,
  output logic vic_found,
  output logic [$clog2(NUM_BLKS)-1:0] vic_idx,
  output logic dst_found,
  output logic [$clog2(NUM_BLKS)-1:0] dst_idx
);
  localparam int BLK_W = $clog2(NUM_BLKS);
  localparam int CNT_W = $clog2(PAGES_PER_BLK+1);

  logic [CNT_W-1:0] best;

  // Strict comparison keeps the earliest index on ties; best starts at zero
  // so a block without stale pages never wins.
  always_comb begin
    best      = '0;
    vic_found = 1'b0;
    vic_idx   = '0;
    for (int b = 0; b < NUM_BLKS; b++) begin
      if (stale_cnt[b] > best) begin
        best      = stale_cnt[b];
        vic_found = 1'b1;
        vic_idx   = BLK_W'(b);
      end
    end
  end

  always_comb begin
    dst_found = 1'b0;
    dst_idx   = '0;
    for (int b = NUM_BLKS-1; b >= 0; b--) begin
      if (blk_free[b]) begin
        dst_found = 1'b1;
        dst_idx   = BLK_W'(b);
      end
    end
  end
endmodule

// File: rtl/gc_engine.sv
module gc_engine
  import gc_pkg::*;
#(
  parameter int NUM_BLKS      = 8,
  parameter int PAGES_PER_BLK = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic host_idle,
  input  logic fg_mode,
  input  logic pd_req,
  input  logic vic_found,
  input  logic [$clog2(NUM_BLKS)-1:0] vic_idx,
  input  logic dst_found,
  input  logic [$clog2(NUM_BLKS)-1:0] dst_idx,
  input  logic [NUM_BLKS-1:0][PAGES_PER_BLK-1:0] live_map,
  input  logic cmd_ready,
  output logic cmd_valid,
  output logic [1:0] cmd_op,
  output logic [$clog2(NUM_BLKS)-1:0] cmd_blk,
  output logic [$clog2(PAGES_PER_BLK)-1:0] cmd_page,
  output logic prog_en,
  output logic [$clog2(NUM_BLKS)-1:0] prog_blk,
  output logic [$clog2(PAGES_PER_BLK)-1:0] prog_page,
  output logic erase_en,
  output logic [$clog2(NUM_BLKS)-1:0] erase_blk,
  output logic halted
);
  localparam int BLK_W  = $clog2(NUM_BLKS);
  localparam int PAGE_W = $clog2(PAGES_PER_BLK);
  localparam logic [PAGE_W:0] SCAN_END = (PAGE_W+1)'(PAGES_PER_BLK);

  eng_state_t         state_q;
  logic [BLK_W-1:0]   vic_q, dst_q;
  logic [PAGE_W:0]    scan_q;
  logic [PAGE_W-1:0]  dpage_q;
  logic               pd_q;
  logic               go, pd_now;
  flash_op_t          op;

  assign go     = fg_mode || host_idle;
  assign pd_now = pd_q || pd_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      vic_q   <= '0;
      dst_q   <= '0;
      scan_q  <= '0;
      dpage_q <= '0;
      pd_q    <= 1'b0;
    end else begin
      if (pd_req) pd_q <= 1'b1;
      case (state_q)
        S_IDLE: begin
          if (pd_now) state_q <= S_HALT;
          else if (go && vic_found && dst_found) begin
            vic_q   <= vic_idx;
            dst_q   <= dst_idx;
            scan_q  <= '0;
            dpage_q <= '0;
            state_q <= S_SCAN;
          end
        end
        S_SCAN: begin
          if (pd_now) state_q <= S_HALT;
          else if (scan_q == SCAN_END) state_q <= S_ER_ARM;
          else if (live_map[vic_q][scan_q[PAGE_W-1:0]]) state_q <= S_RD_ARM;
          else scan_q <= scan_q + 1'b1;
        end
        S_RD_ARM: begin
          if (pd_now) state_q <= S_HALT;
          else if (go) state_q <= S_RD;
        end
        S_RD: if (cmd_ready) state_q <= pd_now ? S_HALT : S_PG_ARM;
        S_PG_ARM: begin
          if (pd_now) state_q <= S_HALT;
          else if (go) state_q <= S_PG;
        end
        S_PG: begin
          if (cmd_ready) begin
            dpage_q <= dpage_q + 1'b1;
            scan_q  <= scan_q + 1'b1;
            state_q <= pd_now ? S_HALT : S_SCAN;
          end
        end
        S_ER_ARM: begin
          if (pd_now) state_q <= S_HALT;
          else if (go) state_q <= S_ER;
        end
        S_ER: if (cmd_ready) state_q <= pd_now ? S_HALT : S_IDLE;
        default: state_q <= S_HALT;
      endcase
    end
  end

  assign cmd_valid = (state_q == S_RD) || (state_q == S_PG) || (state_q == S_ER);

  always_comb begin
    op       = OP_READ;
    cmd_blk  = vic_q;
    cmd_page = scan_q[PAGE_W-1:0];
    if (state_q == S_PG) begin
      op       = OP_PROG;
      cmd_blk  = dst_q;
      cmd_page = dpage_q;
    end else if (state_q == S_ER) begin
      op       = OP_ERASE;
      cmd_page = '0;
    end
  end
  assign cmd_op = op;

  assign prog_en   = (state_q == S_PG) && cmd_ready;
  assign prog_blk  = dst_q;
  assign prog_page = dpage_q;
  assign erase_en  = (state_q == S_ER) && cmd_ready;
  assign erase_blk = vic_q;
  assign halted    = (state_q == S_HALT);
endmodule

// File: rtl/gc_sched.sv
module gc_sched #(
  parameter int NUM_BLKS      = 8,
  parameter int PAGES_PER_BLK = 16,
  parameter int FREE_THRESH   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic [$clog2(NUM_BLKS)-1:0] wr_blk,
  input  logic [$clog2(PAGES_PER_BLK)-1:0] wr_page,
  input  logic inv_en,
  input  logic [$clog2(NUM_BLKS)-1:0] inv_blk,
  input  logic [$clog2(PAGES_PER_BLK)-1:0] inv_page,
  input  logic host_idle,
  input  logic pd_req,
  output logic cmd_valid,
  input  logic cmd_ready,
  output logic [1:0] cmd_op,
  output logic [$clog2(NUM_BLKS)-1:0] cmd_blk,
  output logic [$clog2(PAGES_PER_BLK)-1:0] cmd_page,
  output logic host_stall,
  output logic halted
);
  localparam int BLK_W  = $clog2(NUM_BLKS);
  localparam int PAGE_W = $clog2(PAGES_PER_BLK);
  localparam int CNT_W  = $clog2(PAGES_PER_BLK+1);
  localparam int FCNT_W = $clog2(NUM_BLKS+1);
  localparam logic [FCNT_W-1:0] THR = FCNT_W'(FREE_THRESH);

  logic [NUM_BLKS-1:0][CNT_W-1:0]         stale_cnt;
  logic [NUM_BLKS-1:0][PAGES_PER_BLK-1:0] live_map;
  logic [NUM_BLKS-1:0]                    blk_free;
  logic [FCNT_W-1:0]                      free_cnt;
  logic                                   vic_found, dst_found;
  logic [BLK_W-1:0]                       vic_idx, dst_idx;
  logic                                   prog_en, erase_en;
  logic [BLK_W-1:0]                       prog_blk, erase_blk;
  logic [PAGE_W-1:0]                      prog_page;
  logic                                   wr_accept;

  assign wr_accept = wr_en && !host_stall;

  // Stall with one block of hysteresis above the threshold.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              host_stall <= 1'b0;
    else if (free_cnt < THR) host_stall <= 1'b1;
    else if (free_cnt > THR) host_stall <= 1'b0;
  end

  gc_block_table #(.NUM_BLKS(NUM_BLKS), .PAGES_PER_BLK(PAGES_PER_BLK)) u_table (
    .clk(clk), .rst_n(rst_n),
    .host_wr_en(wr_accept), .host_wr_blk(wr_blk), .host_wr_page(wr_page),
    .host_inv_en(inv_en), .host_inv_blk(inv_blk), .host_inv_page(inv_page),
    .eng_prog_en(prog_en), .eng_prog_blk(prog_blk), .eng_prog_page(prog_page),
    .eng_erase_en(erase_en), .eng_erase_blk(erase_blk),
    .stale_cnt(stale_cnt), .live_map(live_map), .blk_free(blk_free), .free_cnt(free_cnt)
  );

  gc_victim_sel #(.NUM_BLKS(NUM_BLKS), .PAGES_PER_BLK(PAGES_PER_BLK)) u_sel (
    .stale_cnt(stale_cnt), .blk_free(blk_free),
    .vic_found(vic_found), .vic_idx(vic_idx), .dst_found(dst_found), .dst_idx(dst_idx)
  );

  gc_engine #(.NUM_BLKS(NUM_BLKS), .PAGES_PER_BLK(PAGES_PER_BLK)) u_eng (
    .clk(clk), .rst_n(rst_n), .host_idle(host_idle), .fg_mode(host_stall), .pd_req(pd_req),
    .vic_found(vic_found), .vic_idx(vic_idx), .dst_found(dst_found), .dst_idx(dst_idx),
    .live_map(live_map), .cmd_ready(cmd_ready), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_blk(cmd_blk), .cmd_page(cmd_page), .prog_en(prog_en), .prog_blk(prog_blk),
    .prog_page(prog_page), .erase_en(erase_en), .erase_blk(erase_blk), .halted(halted)
  );
endmodule

// File: rtl/gc_sched_chk.sv
module gc_sched_chk #(
  parameter int NUM_BLKS      = 8,
  parameter int PAGES_PER_BLK = 16,
  parameter int FREE_THRESH   = 2
) (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic [1:0] cmd_op,
  input logic [$clog2(NUM_BLKS)-1:0] cmd_blk,
  input logic [$clog2(PAGES_PER_BLK)-1:0] cmd_page,
  input logic host_idle,
  input logic host_stall,
  input logic halted,
  input logic [$clog2(NUM_BLKS+1)-1:0] free_cnt
);
  localparam int FCNT_W = $clog2(NUM_BLKS+1);
  localparam logic [FCNT_W-1:0] THR = FCNT_W'(FREE_THRESH);

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_blk) && $stable(cmd_page)); // R10

  AST_BG_IDLE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) |-> $past(host_idle || host_stall)); // R5

  AST_STALL_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    free_cnt < THR |=> host_stall); // R6

  AST_STALL_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    free_cnt > THR |=> !host_stall); // R7

  AST_STALL_BAND: assert property (@(posedge clk) disable iff (!rst_n)
    free_cnt == THR |=> $stable(host_stall)); // R7

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && !cmd_valid); // R9
endmodule

bind gc_sched gc_sched_chk #(
  .NUM_BLKS(NUM_BLKS), .PAGES_PER_BLK(PAGES_PER_BLK), .FREE_THRESH(FREE_THRESH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_blk(cmd_blk), .cmd_page(cmd_page), .host_idle(host_idle),
  .host_stall(host_stall), .halted(halted), .free_cnt(free_cnt)
);

// File: tb/gc_sched_tb.sv
`timescale 1ns/1ps
module gc_sched_tb;
  localparam int NB = 4;
  localparam int PP = 4;
  localparam int TH = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, inv_en = 1'b0, host_idle = 1'b0, pd_req = 1'b0, cmd_ready = 1'b0;
  logic [1:0] wr_blk = '0, inv_blk = '0, wr_page = '0, inv_page = '0;
  logic cmd_valid, host_stall, halted;
  logic [1:0] cmd_op, cmd_blk, cmd_page;

  int n_chk = 0;
  int n_bad = 0;
  bit reported = 0;
  int mst [NB][PP];   // 0 erased, 1 live, 2 stale

  always #2.5 clk = ~clk;

  gc_sched #(.NUM_BLKS(NB), .PAGES_PER_BLK(PP), .FREE_THRESH(TH)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_blk(wr_blk), .wr_page(wr_page),
    .inv_en(inv_en), .inv_blk(inv_blk), .inv_page(inv_page), .host_idle(host_idle),
    .pd_req(pd_req), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_blk(cmd_blk), .cmd_page(cmd_page), .host_stall(host_stall), .halted(halted)
  );

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 0; inv_en = 0; host_idle = 0; pd_req = 0; cmd_ready = 0;
    for (int b = 0; b < NB; b++) for (int p = 0; p < PP; p++) mst[b][p] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic host_write(int b, int p, bit apply);
    wr_en = 1; wr_blk = 2'(b); wr_page = 2'(p);
    @(negedge clk);
    wr_en = 0;
    if (apply) mst[b][p] = 1;
  endtask

  task automatic host_inv(int b, int p);
    inv_en = 1; inv_blk = 2'(b); inv_page = 2'(p);
    @(negedge clk);
    inv_en = 0;
    if (mst[b][p] == 1) mst[b][p] = 2;
  endtask

  task automatic quiet(int n, string tag);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (cmd_valid) seen = 1;
    end
    chk(tag, seen, 0);
  endtask

  // Waits for an offered command, holds ready low for two cycles, checks the
  // fields against the expectation and their stability, then completes it.
  task automatic expect_op(int op, int b, int p, string tag);
    int waited = 0;
    int enc;
    while (!cmd_valid && waited < 64) begin
      @(negedge clk);
      waited++;
    end
    chk({tag, " command offered"}, int'(cmd_valid), 1);
    if (cmd_valid) begin
      enc = int'(cmd_op) * 256 + int'(cmd_blk) * 16 + int'(cmd_page);
      chk(tag, enc, op * 256 + b * 16 + p);
      repeat (2) @(negedge clk);
      chk("R10 fields held under back-pressure", int'(cmd_op) * 256 + int'(cmd_blk) * 16 + int'(cmd_page)
          + (cmd_valid ? 0 : 4096), enc);
      cmd_ready = 1;
      @(negedge clk);
      cmd_ready = 0;
    end
  endtask

  task automatic run_model_gc(int max_cycles, string tag);
    for (int c = 0; c < max_cycles; c++) begin
      int best = 0, v = -1, d = -1, k = 0;
      for (int b = 0; b < NB; b++) begin
        int cnt = 0;
        for (int p = 0; p < PP; p++) if (mst[b][p] == 2) cnt++;
        if (cnt > best) begin best = cnt; v = b; end
      end
      for (int b = NB-1; b >= 0; b--) begin
        int fr = 1;
        for (int p = 0; p < PP; p++) if (mst[b][p] != 0) fr = 0;
        if (fr == 1) d = b;
      end
      if (v < 0 || d < 0) break;
      for (int p = 0; p < PP; p++) begin
        if (mst[v][p] == 1) begin
          expect_op(0, v, p, {tag, " read"});
          expect_op(1, d, k, {tag, " program"});
          mst[d][k] = 1;
          k++;
        end
      end
      expect_op(2, v, 0, {tag, " erase"});
      for (int p = 0; p < PP; p++) mst[v][p] = 0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    do_reset();
    // R11 reset state
    chk("R11 cmd_valid after reset", int'(cmd_valid), 0);
    chk("R11 host_stall after reset", int'(host_stall), 0);
    chk("R11 halted after reset", int'(halted), 0);

    // Sweep of stale counts on two blocks: R1 R2 R3 R4 R5
    for (int a = 0; a <= PP; a++) begin
      for (int bb = 0; bb <= PP; bb++) begin
        do_reset();
        for (int p = 0; p < PP; p++) host_write(0, p, 1);
        for (int p = 0; p < PP; p++) host_write(1, p, 1);
        for (int p = 0; p < a; p++) host_inv(0, p);
        for (int p = PP - bb; p < PP; p++) host_inv(1, p);
        quiet(8, "R5 no background work while host busy");
        host_idle = 1;
        run_model_gc(4, "R1 R2 R4 victim/sequence");
        quiet(16, "R3 nothing left to reclaim");
        host_idle = 0;
      end
    end

    // Foreground entry and ignored writes: R6 R8
    do_reset();
    for (int p = 0; p < PP; p++) host_write(0, p, 1);
    for (int p = 0; p < PP; p++) host_write(1, p, 1);
    host_write(2, 0, 1);
    repeat (2) @(negedge clk);
    chk("R6 stall below threshold", int'(host_stall), 1);
    host_write(3, 0, 0);
    host_write(2, 1, 0);
    quiet(6, "R3 stalled but no stale page");
    host_inv(2, 0);
    run_model_gc(1, "R6 R8 foreground with host busy");
    repeat (2) @(negedge clk);
    chk("R7 stall held at threshold", int'(host_stall), 1);

    // Hysteresis band: R7
    do_reset();
    for (int p = 0; p < PP; p++) host_write(0, p, 1);
    for (int p = 0; p < PP; p++) host_write(1, p, 1);
    for (int p = 0; p < PP; p++) host_inv(0, p);
    for (int p = 0; p < PP; p++) host_inv(1, p);
    quiet(6, "R5 stale blocks left alone while busy");
    host_write(2, 0, 1);
    run_model_gc(1, "R2 R6 tie goes to lower block");
    repeat (2) @(negedge clk);
    chk("R7 stall kept at threshold", int'(host_stall), 1);
    run_model_gc(1, "R6 foreground continues in band");
    repeat (2) @(negedge clk);
    chk("R7 stall released above threshold", int'(host_stall), 0);

    // Power-down during a held read: R9
    do_reset();
    for (int p = 0; p < PP; p++) host_write(0, p, 1);
    host_inv(0, 0);
    host_idle = 1;
    while (!cmd_valid) @(negedge clk);
    pd_req = 1;
    @(negedge clk);
    pd_req = 0;
    expect_op(0, 0, 1, "R9 read in flight completes");
    quiet(20, "R9 no command after power-down");
    chk("R9 halted after power-down", int'(halted), 1);

    // Power-down while idle: R9
    do_reset();
    pd_req = 1;
    @(negedge clk);
    pd_req = 0;
    @(negedge clk);
    chk("R9 halted from idle", int'(halted), 1);
    host_write(0, 0, 1);
    host_inv(0, 0);
    host_idle = 1;
    quiet(16, "R9 parked engine stays silent");

    report();
  end
endmodule